// File: doc/BRIEF.md
# Dock Condition Flag and Predicate Unit

This block keeps the four condition flags that steer instruction execution at one dock of a switch fabric. Two of them (A and B) are general-purpose and are written only by a flag-update instruction. L reports that the outer loop counter currently holds one, which marks the final pass of an outer loop. S mirrors the sign (top) bit of the dock's data word and is captured whenever that bit of the data latch is loaded.

A flag-update instruction carries a 2-bit predicate and two 8-bit select masks. If the predicate holds, A and B are replaced together. Each new value is the OR of every flag value, true or inverted, that its mask selects. Both new values are formed from the flags as they stood before the update. A separate query input takes any 2-bit predicate code and returns, in the same cycle, whether that predicate holds. Neighbouring decode logic uses this to decide whether an instruction runs or is skipped.

Top module: `dock_flag_unit`

## Requirements
- R1: A synchronous active-low reset clears A, B and S on the clock edge where `rst_n` is sampled low, and this has priority over every other write.
- R2: `flag_l` is 1 exactly when `oc_value` equals one, and it follows `oc_value` combinationally in the same cycle.
- R3: On a clock edge where `dlatch_wr` is 1, S takes the value of `dlatch_top`. When `dlatch_wr` is 0, S keeps its value.
- R4: `query_true` evaluates `query_code` combinationally against the current flags with this encoding: 2'b00 holds when A is 1, 2'b10 holds when B is 1, 2'b01 holds when L is 1, and 2'b11 always holds.
- R5: When an update fires, the new A is the OR of the sources picked by `upd_mask_a`, and the new B is the OR of the sources picked by `upd_mask_b`. The mask bits select the sources as follows: bit 7 = A, bit 6 = not A, bit 5 = B, bit 4 = not B, bit 3 = S, bit 2 = not S, bit 1 = L, bit 0 = not L.
- R6: An all-zero mask writes 0 to its flag. A mask that selects any flag together with its complement writes 1.
- R7: An update with `upd_valid` = 1 takes effect only when `upd_pred` holds under the R4 encoding, evaluated on the flags before the edge. Otherwise A and B keep their values.
- R8: The new A and B are both computed from the flag values before the update and change on the same edge. Masks that cross-select therefore swap A and B.
- R9: With `upd_valid` = 0, A and B keep their values. An update never writes S. L depends on nothing but `oc_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_value | input | OC_W | Current outer loop counter value |
| dlatch_wr | input | 1 | Strobe: the top bit of the data latch is loaded this cycle |
| dlatch_top | input | 1 | Value written to the data latch's top bit |
| upd_valid | input | 1 | A flag-update instruction is presented this cycle |
| upd_pred | input | 2 | Predicate code of the flag-update instruction |
| upd_mask_a | input | 8 | OR-select mask forming the next A |
| upd_mask_b | input | 8 | OR-select mask forming the next B |
| query_code | input | 2 | Predicate code to evaluate |
| query_true | output | 1 | 1 when `query_code` holds on the current flags |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_s | output | 1 | Summary flag S |
| flag_l | output | 1 | Last-iteration flag L |

## Verification
The bench aims at the predicate encoding, where 01 and 10 are easy to swap. A design that decoded them in binary order would make L-conditioned updates fire on B. Directed cases cover the all-zero mask and the flag-plus-complement mask, along with a cross-selecting swap that would turn into a copy if A were written before B was computed. Further cases check that a false predicate or a cleared valid leaves A and B untouched, and that S changes only on the latch strobe and not because of an update mask. Random masks, counter values near one, and strobes fill in the remaining combinations.

// File: rtl/dfu_pkg.sv
// Package: shared widths, predicate codes and the flag bundle for the
// dock flag unit. Assumes the mask layout below is what the instruction
// decoder feeds in; the bit positions are part of the instruction format.
package dfu_pkg;

    localparam int MASK_W = 8;
    localparam int PRED_W = 2;

    // Mask bit positions (decoded by the instruction format).
    localparam int SEL_A_POS  = 7;
    localparam int SEL_NA_POS = 6;
    localparam int SEL_B_POS  = 5;
    localparam int SEL_NB_POS = 4;
    localparam int SEL_S_POS  = 3;
    localparam int SEL_NS_POS = 2;
    localparam int SEL_L_POS  = 1;
    localparam int SEL_NL_POS = 0;

    typedef enum logic [PRED_W-1:0] {
        PRED_IF_A   = 2'b00,
        PRED_IF_L   = 2'b01,
        PRED_IF_B   = 2'b10,
        PRED_ALWAYS = 2'b11
    } pred_e;

    typedef struct packed {
        logic a;
        logic b;
        logic s;
        logic l;
    } flags_t;

endpackage

// File: rtl/dfu_pred_eval.sv
// Module: dfu_pred_eval
// Evaluates one 2-bit predicate code against a flag bundle.
// Assumes: purely combinational; the code uses the pred_e encoding.
module dfu_pred_eval
    import dfu_pkg::*;
(
    input  logic [PRED_W-1:0] code,
    input  flags_t            fl,
    output logic              holds
);

    // Select the flag that the predicate code names.
    always_comb begin
        unique case (pred_e'(code))
            PRED_IF_A:   holds = fl.a;
            PRED_IF_B:   holds = fl.b;
            PRED_IF_L:   holds = fl.l;
            PRED_ALWAYS: holds = 1'b1;
            default:     holds = 1'b0;
        endcase
    end

endmodule

// File: rtl/dfu_mask_or.sv
// Module: dfu_mask_or
// Forms one next-flag value as the OR of the mask-selected true and
// inverted flag values. Assumes: combinational, mask layout from dfu_pkg.
module dfu_mask_or
    import dfu_pkg::*;
(
    input  logic [MASK_W-1:0] sel,
    input  flags_t            fl,
    output logic              val
);

    logic [MASK_W-1:0] src;

    // Place every candidate source at its mask bit position.
    always_comb begin
        src             = '0;
        src[SEL_A_POS]  = fl.a;
        src[SEL_NA_POS] = ~fl.a;
        src[SEL_B_POS]  = fl.b;
        src[SEL_NB_POS] = ~fl.b;
        src[SEL_S_POS]  = fl.s;
        src[SEL_NS_POS] = ~fl.s;
        src[SEL_L_POS]  = fl.l;
        src[SEL_NL_POS] = ~fl.l;
    end

    // OR together the selected sources; an empty mask gives zero.
    always_comb val = |(sel & src);

endmodule

// File: rtl/dfu_state.sv
// Module: dfu_state
// Holds the stored flags A, B and S. Assumes synchronous active-low
// reset with priority; A and B are written together by one enable.
module dfu_state (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ab,
    input  logic a_in,
    input  logic b_in,
    input  logic ld_s,
    input  logic s_in,
    output logic a_q,
    output logic b_q,
    output logic s_q
);

    // Programmer flags: both replaced on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else if (wr_ab) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    // Summary flag: captured with the data latch top bit.
    always_ff @(posedge clk) begin
        if (!rst_n)    s_q <= 1'b0;
        else if (ld_s) s_q <= s_in;
    end

endmodule

// File: rtl/dock_flag_unit.sv
// Module: dock_flag_unit (top)
// Condition flags of one dock and predicate evaluation. Assumes the
// outer counter is held outside and presented on oc_value, and that
// opcode decode upstream raises upd_valid only for flag-update words.
module dock_flag_unit
    import dfu_pkg::*;
#(
    parameter int OC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OC_W-1:0]   oc_value,
    input  logic              dlatch_wr,
    input  logic              dlatch_top,
    input  logic              upd_valid,
    input  logic [PRED_W-1:0] upd_pred,
    input  logic [MASK_W-1:0] upd_mask_a,
    input  logic [MASK_W-1:0] upd_mask_b,
    input  logic [PRED_W-1:0] query_code,
    output logic              query_true,
    output logic              flag_a,
    output logic              flag_b,
    output logic              flag_s,
    output logic              flag_l
);

    localparam int NTGT = 2;               // written flags: A and B
    localparam logic [OC_W-1:0] OC_LAST = OC_W'(1);

    flags_t            cur;
    logic              upd_holds;
    logic [NTGT-1:0]   nxt;
    logic [MASK_W-1:0] masks [NTGT];
    logic              a_q, b_q, s_q;

    // Last-pass flag straight from the counter value.
    always_comb flag_l = (oc_value == OC_LAST);

    // Bundle the current flags for the evaluators.
    always_comb begin
        cur.a = a_q;
        cur.b = b_q;
        cur.s = s_q;
        cur.l = flag_l;
    end

    // Route masks to their target slot: 0 = A, 1 = B.
    always_comb begin
        masks[0] = upd_mask_a;
        masks[1] = upd_mask_b;
    end

    // One OR-select per writable flag, all from the pre-update bundle.
    for (genvar g = 0; g < NTGT; g++) begin : g_tgt
        dfu_mask_or u_or (
            .sel (masks[g]),
            .fl  (cur),
            .val (nxt[g])
        );
    end

    dfu_pred_eval u_upd_pred (
        .code  (upd_pred),
        .fl    (cur),
        .holds (upd_holds)
    );

    dfu_pred_eval u_qry_pred (
        .code  (query_code),
        .fl    (cur),
        .holds (query_true)
    );

    dfu_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ab (upd_valid & upd_holds),
        .a_in  (nxt[0]),
        .b_in  (nxt[1]),
        .ld_s  (dlatch_wr),
        .s_in  (dlatch_top),
        .a_q   (a_q),
        .b_q   (b_q),
        .s_q   (s_q)
    );

    // Drive the flag outputs from the stored state.
    always_comb begin
        flag_a = a_q;
        flag_b = b_q;
        flag_s = s_q;
    end

endmodule

// File: rtl/dfu_checker.sv
// Module: dfu_checker
// Port-level properties of dock_flag_unit, bound to every instance.
// Assumes the same parameters as the top it is bound to.
module dfu_checker #(
    parameter int OC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OC_W-1:0] oc_value,
    input logic            dlatch_wr,
    input logic            dlatch_top,
    input logic            upd_valid,
    input logic [1:0]      upd_pred,
    input logic [7:0]      upd_mask_a,
    input logic [7:0]      upd_mask_b,
    input logic [1:0]      query_code,
    input logic            query_true,
    input logic            flag_a,
    input logic            flag_b,
    input logic            flag_s,
    input logic            flag_l
);

    logic upd_ok;

    // Independent view of whether the update predicate holds.
    always_comb begin
        case (upd_pred)
            2'b00:   upd_ok = flag_a;
            2'b10:   upd_ok = flag_b;
            2'b01:   upd_ok = (oc_value == OC_W'(1));
            default: upd_ok = 1'b1;
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!flag_a && !flag_b && !flag_s)); // R1

    AST_S_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        dlatch_wr |=> (flag_s == $past(dlatch_top))); // R3

    AST_S_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !dlatch_wr |=> $stable(flag_s)); // R3

    AST_QUERY_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (query_code == 2'b11) |-> query_true); // R4

    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_pred == 2'b11 && upd_mask_a == 8'h00) |=> !flag_a); // R6

    AST_PAIR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_pred == 2'b11 && upd_mask_b[5] && upd_mask_b[4]) |=> flag_b); // R6

    AST_PRED_FALSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_ok) |=> ($stable(flag_a) && $stable(flag_b))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(flag_a) && $stable(flag_b))); // R9

endmodule

bind dock_flag_unit dfu_checker #(.OC_W(OC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_value   (oc_value),
    .dlatch_wr  (dlatch_wr),
    .dlatch_top (dlatch_top),
    .upd_valid  (upd_valid),
    .upd_pred   (upd_pred),
    .upd_mask_a (upd_mask_a),
    .upd_mask_b (upd_mask_b),
    .query_code (query_code),
    .query_true (query_true),
    .flag_a     (flag_a),
    .flag_b     (flag_b),
    .flag_s     (flag_s),
    .flag_l     (flag_l)
);

// File: tb/dock_flag_unit_tb_top.sv
// Bench for dock_flag_unit: directed corners plus seeded random cycles,
// compared against a flag model built from the requirements.
module dock_flag_unit_tb_top;

    localparam int OC_W = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [OC_W-1:0] oc_value;
    logic            dlatch_wr, dlatch_top, upd_valid;
    logic [1:0]      upd_pred, query_code;
    logic [7:0]      upd_mask_a, upd_mask_b;
    logic            query_true, flag_a, flag_b, flag_s, flag_l;

    int n_chk = 0;
    int n_bad = 0;
    logic ma = 1'b0, mb = 1'b0, ms = 1'b0;   // model flags

    always #4 clk = ~clk;   // 125 MHz

    dock_flag_unit #(.OC_W(OC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .oc_value(oc_value),
        .dlatch_wr(dlatch_wr), .dlatch_top(dlatch_top),
        .upd_valid(upd_valid), .upd_pred(upd_pred),
        .upd_mask_a(upd_mask_a), .upd_mask_b(upd_mask_b),
        .query_code(query_code), .query_true(query_true),
        .flag_a(flag_a), .flag_b(flag_b), .flag_s(flag_s), .flag_l(flag_l)
    );

    // R4 encoding: 00 A, 10 B, 01 L, 11 always.
    function automatic logic f_pred(logic [1:0] c, logic a, logic b, logic l);
        case (c)
            2'b00:   return a;
            2'b10:   return b;
            2'b01:   return l;
            default: return 1'b1;
        endcase
    endfunction

    // R5 layout: 7 A, 6 ~A, 5 B, 4 ~B, 3 S, 2 ~S, 1 L, 0 ~L.
    function automatic logic f_mask(logic [7:0] m, logic a, logic b, logic s, logic l);
        return (m[7] & a) | (m[6] & ~a) | (m[5] & b) | (m[4] & ~b) |
               (m[3] & s) | (m[2] & ~s) | (m[1] & l) | (m[0] & ~l);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, advance model,
    // then compare stored flags at the next negedge.
    task automatic cycle(logic [OC_W-1:0] oc, logic dw, logic dt, logic uv,
                         logic [1:0] up, logic [7:0] mka, logic [7:0] mkb,
                         logic [1:0] qc, string tag);
        logic l, na, nb;
        oc_value = oc; dlatch_wr = dw; dlatch_top = dt; upd_valid = uv;
        upd_pred = up; upd_mask_a = mka; upd_mask_b = mkb; query_code = qc;
        #1;
        l = (oc == OC_W'(1));
        check("R2 flag_l", flag_l, l);
        check("R4 query_true", query_true, f_pred(qc, ma, mb, l));
        na = ma; nb = mb;
        if (uv && f_pred(up, ma, mb, l)) begin   // R7, R8
            na = f_mask(mka, ma, mb, ms, l);
            nb = f_mask(mkb, ma, mb, ms, l);
        end
        if (dw) ms = dt;                          // R3
        ma = na; mb = nb;
        @(posedge clk);
        @(negedge clk);
        check({tag, " flag_a"}, flag_a, ma);
        check({tag, " flag_b"}, flag_b, mb);
        check({tag, " flag_s"}, flag_s, ms);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; oc_value = '0; dlatch_wr = 1'b1; dlatch_top = 1'b1;
        upd_valid = 1'b1; upd_pred = 2'b11; upd_mask_a = 8'hFF; upd_mask_b = 8'hFF;
        query_code = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset wins over strobe and update
        check("R1 flag_a", flag_a, 1'b0);
        check("R1 flag_b", flag_b, 1'b0);
        check("R1 flag_s", flag_s, 1'b0);
        rst_n = 1'b1;

        // R6: flag with complement gives 1 on both
        cycle(16'd5, 0, 0, 1, 2'b11, 8'hC0, 8'h30, 2'b11, "R6 pair");
        // R6: zero mask gives 0 on A, keep B at 1 via ~L
        cycle(16'd5, 0, 0, 1, 2'b11, 8'h00, 8'h01, 2'b00, "R6 zero");
        // R8: swap A(0) and B(1)
        cycle(16'd5, 0, 0, 1, 2'b11, 8'h20, 8'h80, 2'b10, "R8 swap");
        cycle(16'd5, 0, 0, 1, 2'b11, 8'h20, 8'h80, 2'b00, "R8 swap back");
        // R3: S load, then update mask cannot move S (R9)
        cycle(16'd5, 1, 1, 0, 2'b11, 8'h00, 8'h00, 2'b11, "R3 load");
        cycle(16'd5, 0, 0, 1, 2'b11, 8'h04, 8'h08, 2'b11, "R9 S untouched");
        // R7: predicate on A while A=0 -> hold
        cycle(16'd5, 0, 0, 1, 2'b00, 8'hFF, 8'h00, 2'b00, "R7 false A");
        // R7: predicate on L: false at oc=2, true at oc=1
        cycle(16'd2, 0, 0, 1, 2'b01, 8'h40, 8'h40, 2'b01, "R7 false L");
        cycle(16'd1, 0, 0, 1, 2'b01, 8'h02, 8'h01, 2'b01, "R5 L sel");
        cycle(16'd0, 1, 0, 0, 2'b11, 8'hFF, 8'hFF, 2'b10, "R9 idle");

        for (int i = 0; i < 3000; i++) begin
            logic [OC_W-1:0] oc;
            oc = ($urandom % 4 == 0) ? OC_W'($urandom % 3) : OC_W'($urandom);
            cycle(oc, 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0),
                  2'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), "R5 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule